// File: doc/BRIEF.md
# CPU memory map with I/O decode

This block is the memory side of a small 8-bit processor system with a 16-bit address bus. It holds byte-wide RAM whose contents are fixed at power-up (a reset vector plus a short start-up routine), and it takes a window of four addresses away from the RAM and uses it for I/O. A write to the first address sets a four-bit LED latch. A write to the second pushes a byte toward a transmit FIFO. A read of the third pops a byte from a receive FIFO. The fourth address returns the FIFO status.

The processor drives an address, a write enable and write data every cycle and takes read data one cycle later. The FIFOs sit outside the block and expose their full or empty flags. The block refuses a push into a full FIFO and a pop from an empty one. The block also produces the processor's power-on reset from a counter that starts at configuration.

Top module: `cpu_memmap`

## Requirements
- R1: RAM holds 2**RAM_AW bytes. It is indexed by the low RAM_AW address bits, so higher addresses alias onto it. RAM_AW = 16 gives the full 64 KiB.
- R2: Reads are synchronous. `cpu_rdata` shows the addressed byte after the first rising edge following the address, and this includes the I/O addresses.
- R3: At power-up, 0xFFFC holds the low byte 0x00 and 0xFFFD holds the high byte 0x04 of the reset vector 0x0400.
- R4: At power-up the start-up routine occupies 0x0400–0x0408 as A9, BOOT_IMM, EA, EA, EA, EA, 4C, 02, 04. This is a load-immediate, then four NOPs, then a jump back to 0x0402. Every other byte is 0x00.
- R5: A write to 0xE000 latches bits 3:0 of the data into `led` and does not store to RAM. A read of 0xE000 returns {4'b0, led}. `led` changes only on such a write.
- R6: A write to 0xE001 raises `tx_push` with `tx_data` equal to the written byte when `tx_full` is low. It never stores to RAM, and no push occurs while `tx_full` is high.
- R7: A read of 0xE002 raises `rx_pop` and returns `rx_data` when `rx_empty` is low. When `rx_empty` is high the read returns 0x00 and no pop occurs.
- R8: A read of 0xE003 returns bit 0 = NOT rx_empty and bit 1 = tx_full, with all other bits zero. A read of 0xE001 returns 0x00. Writes to 0xE002 and 0xE003 have no effect.
- R9: From power-up, `cpu_rst` is high for exactly RST_CYCLES clock cycles (16 by default). It then goes low and stays low.
- R10: While `cpu_rst` is high, `led` is cleared, and processor writes, pushes and pops have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| cpu_addr | input | 16 | Processor address |
| cpu_we | input | 1 | Processor write enable |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Read data, one cycle after the address |
| cpu_rst | output | 1 | Power-on reset to the processor, active high |
| led | output | 4 | LED latch |
| tx_push | output | 1 | Push strobe to the transmit FIFO |
| tx_data | output | 8 | Byte pushed to the transmit FIFO |
| tx_full | input | 1 | Transmit FIFO full |
| rx_pop | output | 1 | Pop strobe to the receive FIFO |
| rx_data | input | 8 | Head byte of the receive FIFO |
| rx_empty | input | 1 | Receive FIFO empty |

## Verification
The bench builds the block with RAM_AW = 12, RST_CYCLES = 16 and BOOT_IMM = 0x42. The 4 KiB RAM makes aliasing visible: 0x1123 lands on 0x0123, and the I/O window overlays RAM bytes 0x000–0x003, so the bench can show that those bytes survive writes to the I/O addresses. Its FIFO models are four entries deep, so a few writes fill the transmit side, which brings the suppressed push and the status bits within reach.

// File: rtl/cpu_memmap.sv
module cpu_memmap #(
  parameter int          RAM_AW     = 12,
  parameter int          RST_CYCLES = 16,
  parameter logic [15:0] IO_BASE    = 16'hE000,
  parameter logic [15:0] RESET_VEC  = 16'h0400,
  parameter logic [7:0]  BOOT_IMM   = 8'h42
) (
  input  logic        clk,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_we,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  output logic        cpu_rst,
  output logic [3:0]  led,
  output logic        tx_push,
  output logic [7:0]  tx_data,
  input  logic        tx_full,
  output logic        rx_pop,
  input  logic [7:0]  rx_data,
  input  logic        rx_empty
);
  localparam int DEPTH = 1 << RAM_AW;
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [RAM_AW-1:0] VEC_IX  = RAM_AW'(16'hFFFC);
  localparam logic [RAM_AW-1:0] BOOT_IX = RAM_AW'(RESET_VEC);
  localparam logic [15:0]       SPIN    = RESET_VEC + 16'd2;

  logic [7:0]       ram [DEPTH];
  logic [CNT_W-1:0] por_cnt = '0;
  logic [3:0]       led_q = '0;
  logic             io_hit;
  logic [1:0]       io_sel;

  initial begin
    for (int i = 0; i < DEPTH; i++) ram[i] = 8'h00;
    ram[VEC_IX]                  = RESET_VEC[7:0];
    ram[VEC_IX + RAM_AW'(1)]     = RESET_VEC[15:8];
    ram[BOOT_IX]                 = 8'hA9;
    ram[BOOT_IX + RAM_AW'(1)]    = BOOT_IMM;
    for (int k = 2; k < 6; k++) ram[BOOT_IX + RAM_AW'(k)] = 8'hEA;
    ram[BOOT_IX + RAM_AW'(6)]    = 8'h4C;
    ram[BOOT_IX + RAM_AW'(7)]    = SPIN[7:0];
    ram[BOOT_IX + RAM_AW'(8)]    = SPIN[15:8];
  end

  assign cpu_rst = (por_cnt != CNT_W'(RST_CYCLES));

  always_ff @(posedge clk)
    if (cpu_rst) por_cnt <= por_cnt + 1'b1;

  assign io_hit  = (cpu_addr[15:2] == IO_BASE[15:2]);
  assign io_sel  = cpu_addr[1:0];
  assign tx_data = cpu_wdata;
  assign tx_push = !cpu_rst && cpu_we && io_hit && io_sel == 2'd1 && !tx_full;
  assign rx_pop  = !cpu_rst && !cpu_we && io_hit && io_sel == 2'd2 && !rx_empty;
  assign led     = led_q;

  always_ff @(posedge clk)
    if (cpu_rst)                                 led_q <= '0;
    else if (cpu_we && io_hit && io_sel == 2'd0) led_q <= cpu_wdata[3:0];

  always_ff @(posedge clk)
    if (!cpu_rst && cpu_we && !io_hit) ram[cpu_addr[RAM_AW-1:0]] <= cpu_wdata;

  always_ff @(posedge clk)
    if (!io_hit) cpu_rdata <= ram[cpu_addr[RAM_AW-1:0]];
    else
      case (io_sel)
        2'd0: cpu_rdata <= {4'b0, led_q};
        2'd1: cpu_rdata <= 8'h00;
        2'd2: cpu_rdata <= rx_empty ? 8'h00 : rx_data;
        default: cpu_rdata <= {6'b0, tx_full, !rx_empty};
      endcase
endmodule

module cpu_memmap_chk #(
  parameter logic [15:0] IO_BASE = 16'hE000
) (
  input logic        clk,
  input logic [15:0] cpu_addr,
  input logic        cpu_we,
  input logic [7:0]  cpu_rdata,
  input logic        cpu_rst,
  input logic [3:0]  led,
  input logic        tx_push,
  input logic        tx_full,
  input logic        rx_pop,
  input logic        rx_empty
);
  // R6
  tx_push_guard_chk: assert property (@(posedge clk) tx_push |-> (!tx_full && cpu_we));
  // R7
  rx_pop_guard_chk: assert property (@(posedge clk) rx_pop |-> (!rx_empty && !cpu_we));
  // R9
  rst_release_chk: assert property (@(posedge clk) !cpu_rst |=> !cpu_rst);
  // R10
  led_clear_chk: assert property (@(posedge clk) cpu_rst |=> led == 4'h0);
  // R10
  no_io_in_reset_chk: assert property (@(posedge clk) cpu_rst |-> (!tx_push && !rx_pop));
  // R5
  led_hold_chk: assert property (@(posedge clk) disable iff (cpu_rst)
    !(cpu_we && cpu_addr == IO_BASE) |=> $stable(led));
  // R8
  stat_pad_chk: assert property (@(posedge clk) disable iff (cpu_rst)
    (!cpu_we && cpu_addr == (IO_BASE | 16'd3)) |=> cpu_rdata[7:2] == 6'b0);
endmodule

bind cpu_memmap cpu_memmap_chk #(.IO_BASE(IO_BASE)) u_chk (
  .clk(clk), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_rdata(cpu_rdata),
  .cpu_rst(cpu_rst), .led(led), .tx_push(tx_push), .tx_full(tx_full),
  .rx_pop(rx_pop), .rx_empty(rx_empty)
);

// File: tb/tb_cpu_memmap.sv
`timescale 1ns/1ps
module tb_cpu_memmap;
  logic        clk = 1'b0;
  logic [15:0] cpu_addr;
  logic        cpu_we;
  logic [7:0]  cpu_wdata;
  logic [7:0]  cpu_rdata;
  logic        cpu_rst;
  logic [3:0]  led;
  logic        tx_push, rx_pop, tx_full, rx_empty;
  logic [7:0]  tx_data, rx_data;

  logic [7:0] tx_q [4];
  logic [7:0] rx_q [4];
  int tx_cnt = 0;
  int rx_cnt = 0;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  cpu_memmap #(.RAM_AW(12), .RST_CYCLES(16), .BOOT_IMM(8'h42)) dut (
    .clk(clk), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_rst(cpu_rst), .led(led),
    .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty)
  );

  assign tx_full  = (tx_cnt == 4);
  assign rx_empty = (rx_cnt == 0);
  assign rx_data  = rx_q[0];

  always @(posedge clk) begin
    if (tx_push && tx_cnt < 4) begin tx_q[tx_cnt] <= tx_data; tx_cnt <= tx_cnt + 1; end
    if (rx_pop && rx_cnt > 0) begin
      for (int i = 0; i < 3; i++) rx_q[i] <= rx_q[i+1];
      rx_cnt <= rx_cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_we = 1'b1; cpu_wdata = d;
    @(negedge clk); cpu_we = 1'b0; cpu_addr = 16'h0010;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_we = 1'b0;
    @(negedge clk); d = cpu_rdata; cpu_addr = 16'h0010;
  endtask

  task automatic expect_rd(input logic [15:0] a, input logic [7:0] e, input string req);
    logic [7:0] d;
    rd(a, d);
    chk(d == e, req, d, e);
  endtask

  task automatic t_reset();
    int n = 0;
    #1;
    chk(cpu_rst == 1'b1, "R9 reset high at start", cpu_rst, 1);
    chk(led == 4'h0, "R10 led clear in reset", led, 0);
    while (cpu_rst && n < 100) begin @(posedge clk); #1; n++; end
    cpu_we = 1'b0; cpu_addr = 16'h0010;
    chk(n == 16, "R9 reset length", n, 16);
    chk(tx_cnt == 0, "R10 no push in reset", tx_cnt, 0);
    chk(led == 4'h0, "R10 no led write in reset", led, 0);
    repeat (3) @(posedge clk); #1;
    chk(cpu_rst == 1'b0, "R9 reset stays low", cpu_rst, 0);
  endtask

  task automatic t_boot();
    expect_rd(16'hFFFC, 8'h00, "R3 vector low");
    expect_rd(16'hFFFD, 8'h04, "R3 vector high");
    expect_rd(16'h0400, 8'hA9, "R4 load opcode");
    expect_rd(16'h0401, 8'h42, "R4 immediate");
    for (int a = 16'h0402; a < 16'h0406; a++) expect_rd(16'(a), 8'hEA, "R4 nop");
    expect_rd(16'h0406, 8'h4C, "R4 jump opcode");
    expect_rd(16'h0407, 8'h02, "R4 jump low");
    expect_rd(16'h0408, 8'h04, "R4 jump high");
    expect_rd(16'h0409, 8'h00, "R4 zero fill");
  endtask

  task automatic t_ram();
    logic [7:0] d;
    wr(16'h0123, 8'h5C);
    @(negedge clk); cpu_addr = 16'h0123;
    @(posedge clk); #1; d = cpu_rdata;
    chk(d == 8'h5C, "R2 data one cycle after address", d, 8'h5C);
    cpu_addr = 16'h0010;
    wr(16'h1123, 8'h77);
    expect_rd(16'h0123, 8'h77, "R1 alias modulo depth");
  endtask

  task automatic t_led();
    wr(16'h0000, 8'h33);
    wr(16'hE000, 8'hA5);
    chk(led == 4'h5, "R5 led latch", led, 5);
    expect_rd(16'hE000, 8'h05, "R5 led readback");
    expect_rd(16'h0000, 8'h33, "R5 no ram store");
    wr(16'h0000, 8'h3C);
    chk(led == 4'h5, "R5 led unchanged by ram write", led, 5);
  endtask

  task automatic t_tx();
    wr(16'h0001, 8'h11);
    for (int i = 0; i < 4; i++) wr(16'hE001, 8'(8'h41 + i));
    chk(tx_cnt == 4, "R6 four pushes", tx_cnt, 4);
    chk(tx_q[0] == 8'h41, "R6 first byte", tx_q[0], 8'h41);
    chk(tx_q[3] == 8'h44, "R6 last byte", tx_q[3], 8'h44);
    wr(16'hE001, 8'h99);
    chk(tx_cnt == 4, "R6 push suppressed when full", tx_cnt, 4);
    chk(tx_q[3] == 8'h44, "R6 full fifo untouched", tx_q[3], 8'h44);
    expect_rd(16'h0001, 8'h11, "R6 no ram store");
    expect_rd(16'hE003, 8'h02, "R8 status tx full rx empty");
    expect_rd(16'hE001, 8'h00, "R8 tx address reads zero");
    @(negedge clk); tx_cnt = 0;
  endtask

  task automatic t_rx();
    wr(16'h0002, 8'h21);
    wr(16'h0003, 8'h22);
    expect_rd(16'hE002, 8'h00, "R7 empty read zero");
    chk(rx_cnt == 0, "R7 no pop when empty", rx_cnt, 0);
    @(negedge clk); rx_q[0] = 8'h5A; rx_q[1] = 8'h6B; rx_cnt = 2;
    expect_rd(16'hE003, 8'h01, "R8 status rx available");
    expect_rd(16'hE002, 8'h5A, "R7 pop first");
    chk(rx_cnt == 1, "R7 one pop", rx_cnt, 1);
    expect_rd(16'hE002, 8'h6B, "R7 pop second");
    expect_rd(16'hE002, 8'h00, "R7 drained read zero");
    chk(rx_cnt == 0, "R7 count after drain", rx_cnt, 0);
    wr(16'hE002, 8'h77);
    wr(16'hE003, 8'h78);
    expect_rd(16'h0002, 8'h21, "R8 write to rx address ignored");
    expect_rd(16'h0003, 8'h22, "R8 write to status ignored");
    chk(led == 4'h5, "R8 led untouched", led, 5);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cpu_addr = 16'hE001; cpu_we = 1'b1; cpu_wdata = 8'hFF;
    t_reset();
    t_boot();
    t_ram();
    t_led();
    t_tx();
    t_rx();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule